// File: doc/BRIEF.md
# Dual-Channel Serial DAC Word Loader

This block is the digital front end of a two-channel converter. It receives 16-bit command words over a three-wire serial link, made up of a serial clock, an active-low frame strobe and a data line. It splits each word into a channel-select bit, a power-down bit and a 12-bit two's complement code. When the frame strobe returns high, it writes the code into the holding register of the selected channel. All three serial inputs are resynchronised into the system clock domain. Edges are found by comparing successive samples, so the system clock must run at least four times faster than the serial clock.

A small state machine tracks the frame. ST_IDLE waits while the strobe is high. It moves to ST_SHIFT when the synchronised strobe is seen low. From ST_SHIFT it moves to ST_COMMIT when the strobe is seen high again. ST_COMMIT lasts one cycle, in which the holding registers and the power-down flag are written. From ST_COMMIT the machine goes back to ST_SHIFT if the strobe is already low again, otherwise to ST_IDLE. Bits are shifted on every synchronised serial clock rise while the strobe is low, independent of the state.

For each channel the block presents the stored code and an offset-binary copy for the converter core. It also presents the power-down flag from the most recent frame.

Top module: `dac_loader`

## Requirements
- R1: Each rising edge of `ser_clk` seen while `ser_frame_n` is low shifts `ser_din` into the least significant end of a 16-bit shift register, so the first bit sent ends up as bit 15.
- R2: Word layout, by shift register position after 16 bits: bit 15 is the channel select, bit 14 is don't-care, bit 13 is power-down, bit 12 is a fixed zero that is ignored, and bits 11..0 are the code, sent most significant bit first. The values of bits 14 and 12 have no effect on any output.
- R3: A rising edge of `ser_frame_n` commits shift register bits 11..0 to the selected channel. The outputs show the new values within 8 system clocks of the edge.
- R4: A select bit of 0 writes `code_a` and a select bit of 1 writes `code_b`. The register of the other channel keeps its value.
- R5: `shdn` takes the value of shift register bit 13 on every commit, and it changes at no other time.
- R6: Serial clock edges while `ser_frame_n` is high leave the shift register, and therefore later commits, unchanged.
- R7: After reset, `code_a` and `code_b` are 000h (bipolar zero), `shdn` is 0 and the shift register is all zeros.
- R8: `ofs_a` and `ofs_b` equal the stored code plus 2048, modulo 4096. So 800h gives 0, 000h gives 2048, and 7FFh gives 4095.
- R9: A frame with fewer than 16 serial clock edges still commits bits 11..0 of the shift register. The select bit and the power-down bit are taken from bit 15 and bit 13, which may then hold bits left over from earlier frames.
- R10: Codes are 12-bit two's complement: 7FFh is positive full scale, 000h is bipolar zero, FFFh is one step below zero, and 800h is negative full scale. Every code is stored without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_frame_n | input | 1 | Active-low frame strobe; its rising edge commits the word |
| ser_din | input | 1 | Serial data, first bit is the channel select |
| code_a | output | 12 | Channel A two's complement code |
| code_b | output | 12 | Channel B two's complement code |
| ofs_a | output | 12 | Channel A code in offset binary |
| ofs_b | output | 12 | Channel B code in offset binary |
| shdn | output | 1 | Power-down request for the converter core |

## Verification
The main test is a sweep of 256 codes per channel, spread so that every nibble value appears in each digit. The channel alternates from word to word, and the power-down bit and the two unused bits change with the code. This shows whether the select bit steers writes correctly, whether the idle channel holds its value, and whether the unused bits leak into any output. The full-scale, zero and one-step-below-zero codes are sent on their own, which separates sign handling from the offset-binary conversion. Serial clock pulses with the strobe high, followed by a 12-edge frame, show whether those pulses reach the shift register, and whether short frames take the select and power-down bits from leftover positions.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ld_state_t;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign level = chain_q[STAGES-1];
endmodule

// File: rtl/dac_shifter.sv
module dac_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_lvl,
    input  logic              frame_lvl,
    input  logic              din_lvl,
    output logic [WORD_W-1:0] word
);
    logic sclk_prev;
    logic take_bit;

    assign take_bit = sclk_lvl && !sclk_prev && !frame_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            word      <= '0;
        end else begin
            sclk_prev <= sclk_lvl;
            if (take_bit) word <= {word[WORD_W-2:0], din_lvl};
        end
    end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] ofs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    code <= '0;
        else if (load) code <= code_in;
    end

    assign ofs = {~code[CODE_W-1], code[CODE_W-2:0]};
endmodule

// File: rtl/dac_loader.sv
module dac_loader
    import dac_loader_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_frame_n,
    input  logic              ser_din,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic [CODE_W-1:0] ofs_a,
    output logic [CODE_W-1:0] ofs_b,
    output logic              shdn
);
    localparam int SEL_POS = WORD_W - 1;
    localparam int PD_POS  = WORD_W - 3;
    localparam int NCH     = 2;

    logic              sclk_lvl, frame_lvl, din_lvl;
    logic [WORD_W-1:0] sr;
    ld_state_t         st, st_nx;
    logic              commit;
    logic [CODE_W-1:0] ch_code [NCH];
    logic [CODE_W-1:0] ch_ofs  [NCH];

    dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk (
        .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .level(sclk_lvl));
    dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_frame (
        .clk(clk), .rst_n(rst_n), .async_in(ser_frame_n), .level(frame_lvl));
    dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_din (
        .clk(clk), .rst_n(rst_n), .async_in(ser_din), .level(din_lvl));

    dac_shifter #(.WORD_W(WORD_W)) i_shifter (
        .clk(clk), .rst_n(rst_n), .sclk_lvl(sclk_lvl),
        .frame_lvl(frame_lvl), .din_lvl(din_lvl), .word(sr));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (!frame_lvl) st_nx = ST_SHIFT;
            ST_SHIFT:  if (frame_lvl)  st_nx = ST_COMMIT;
            ST_COMMIT: st_nx = frame_lvl ? ST_IDLE : ST_SHIFT;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    assign commit = (st == ST_COMMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shdn <= 1'b0;
        else if (commit) shdn <= sr[PD_POS];
    end

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
            logic sel_hit;
            if (ch == 0) begin : g_a
                assign sel_hit = !sr[SEL_POS];
            end else begin : g_b
                assign sel_hit = sr[SEL_POS];
            end
            dac_channel #(.CODE_W(CODE_W)) i_chan (
                .clk(clk), .rst_n(rst_n), .load(commit && sel_hit),
                .code_in(sr[CODE_W-1:0]), .code(ch_code[ch]), .ofs(ch_ofs[ch]));
        end
    endgenerate

    assign code_a = ch_code[0];
    assign code_b = ch_code[1];
    assign ofs_a  = ch_ofs[0];
    assign ofs_b  = ch_ofs[1];
endmodule

// File: rtl/dac_loader_checker.sv
module dac_loader_checker
    import dac_loader_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input ld_state_t         st,
    input logic              frame_lvl,
    input logic [WORD_W-1:0] sr,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b,
    input logic              shdn
);
    // R6: with the strobe high, the shift register does not move
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_lvl |=> (sr == $past(sr)));

    // R3: a strobe rise leads to the commit state on the next cycle
    assert_commit_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_lvl) |=> (st == ST_COMMIT));

    // R4: a write to channel A leaves channel B alone, and the other way round
    assert_keep_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COMMIT && !sr[WORD_W-1]) |=> (code_b == $past(code_b)));
    assert_keep_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COMMIT && sr[WORD_W-1]) |=> (code_a == $past(code_a)));

    // R5: outputs move only on a commit
    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_COMMIT) |=> ($stable(shdn) && $stable(code_a) && $stable(code_b)));
endmodule

bind dac_loader dac_loader_checker #(.WORD_W(WORD_W), .CODE_W(CODE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .frame_lvl(frame_lvl), .sr(sr),
    .code_a(code_a), .code_b(code_b), .shdn(shdn));

// File: tb/test_dac_loader.sv
module test_dac_loader;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;
    localparam int LIMIT      = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_frame_n = 1'b1;
    logic        ser_din = 1'b0;
    logic [11:0] code_a, code_b, ofs_a, ofs_b;
    logic        shdn;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 0;

    logic [15:0] m_sr = '0;
    logic [11:0] m_a = '0, m_b = '0;
    logic        m_sd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_loader i_dac_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_frame_n(ser_frame_n),
        .ser_din(ser_din), .code_a(code_a), .code_b(code_b),
        .ofs_a(ofs_a), .ofs_b(ofs_b), .shdn(shdn));

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] to_ofs(input logic [11:0] c);
        int v;
        v = (int'(c) + 2048) % 4096;
        return v[11:0];
    endfunction

    task automatic check_all(input string req);
        logic [48:0] act, exp;
        act = {code_a, code_b, ofs_a, ofs_b, shdn};
        exp = {m_a, m_b, to_ofs(m_a), to_ofs(m_b), m_sd};
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual a=%h b=%h oa=%h ob=%h sd=%b expected a=%h b=%h oa=%h ob=%h sd=%b",
                     req, code_a, code_b, ofs_a, ofs_b, shdn,
                     m_a, m_b, to_ofs(m_a), to_ofs(m_b), m_sd);
        end
    endtask

    // sends the low nbits of w, first bit = w[nbits-1]
    task automatic send_frame(input logic [15:0] w, input int nbits);
        ser_frame_n = 1'b0;
        wait_clks(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_din = w[i];
            wait_clks(HALF_SCLK);
            ser_clk = 1'b1;
            m_sr = {m_sr[14:0], w[i]};
            wait_clks(HALF_SCLK);
            ser_clk = 1'b0;
        end
        wait_clks(2);
        ser_frame_n = 1'b1;
        if (m_sr[15]) m_b = m_sr[11:0];
        else          m_a = m_sr[11:0];
        m_sd = m_sr[13];
        wait_clks(8);
    endtask

    function automatic logic [15:0] mk_word(input logic sel, input logic junk14,
                                            input logic sd, input logic junk12,
                                            input logic [11:0] c);
        return {sel, junk14, sd, junk12, c};
    endfunction

    initial begin
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(2);
        check_all("R7 reset state");

        // R10/R8 corner codes on both channels
        send_frame(mk_word(1'b0, 1'b0, 1'b0, 1'b0, 12'h7FF), 16);
        check_all("R10 R8 positive full scale A");
        send_frame(mk_word(1'b1, 1'b1, 1'b0, 1'b1, 12'h800), 16);
        check_all("R10 R8 negative full scale B");
        send_frame(mk_word(1'b0, 1'b0, 1'b1, 1'b0, 12'hFFF), 16);
        check_all("R10 R5 one below zero A with power-down");
        send_frame(mk_word(1'b1, 1'b0, 1'b0, 1'b0, 12'h000), 16);
        check_all("R10 R5 bipolar zero B, power-down cleared");

        // R6: serial clock pulses with the strobe high
        send_frame(mk_word(1'b0, 1'b0, 1'b0, 1'b0, 12'h5A3), 16);
        check_all("R1 R3 load A before idle pulses");
        for (int k = 0; k < 6; k++) begin
            ser_din = 1'b1;
            wait_clks(HALF_SCLK);
            ser_clk = 1'b1;
            wait_clks(HALF_SCLK);
            ser_clk = 1'b0;
        end
        wait_clks(8);
        check_all("R6 idle pulses change no output");

        // R9: 12-edge frame, select/power-down from leftovers (model shifts only in frames)
        send_frame(16'h0C3E, 12);
        check_all("R9 R6 short frame of 12 edges");
        send_frame(16'h00A5, 8);
        check_all("R9 short frame of 8 edges");
        send_frame(mk_word(1'b1, 1'b0, 1'b1, 1'b0, 12'h123), 16);
        check_all("R9 full frame after short ones");

        // sweep: both channels, every nibble value in every digit
        for (int i = 0; i < 512; i++) begin
            logic [11:0] c;
            logic [8:0]  iv;
            iv = 9'(i);
            c  = {iv[8:1], iv[4:1]} ^ {4'h0, iv[8:5], 4'h0};
            send_frame(mk_word(iv[0], iv[1], iv[2], iv[3], c), 16);
            check_all(iv[0] ? "R2 R4 R8 sweep channel B" : "R2 R4 R8 sweep channel A");
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule